// File: doc/BRIEF.md
# Flash Operation Status Poller

This block produces the word a host sees when it reads a parallel flash device while a program or erase operation is running. An outside timer asserts `busy` for the length of the operation. An outside array supplies `array_data` for the addressed word. While `busy` is high, each read returns a status word. Bit 7 reports the kind of operation: it is 0 for an erase, and for a program it is the inverse of bit 7 of the word being written. Bit 6 flips on every read. Software decides that the operation has finished when two back-to-back reads agree in bit 6. Once `busy` is low, reads return the real array contents.

The controller has three states. `PS_ARRAY` is the array-read state. `PS_PROG` is the program-busy state. `PS_ERASE` is the erase-busy state.

- Start transition: from `PS_ARRAY`, a high `busy` moves the controller to `PS_ERASE` when `op_erase` is 1, or to `PS_PROG` when `op_erase` is 0. In that same cycle it captures the operation type and `final_data`, and clears the toggle.
- Hold transition: each busy state stays where it is while `busy` remains high.
- Finish transition: each busy state returns to `PS_ARRAY` on the first cycle that `busy` is low.

A read is one cycle with `rd_stb` high. Its result is registered into `rd_data` at that clock edge, and `rd_data` holds that value until the next read.

Top module: `op_status_poller`

## Requirements
- R1: During reset, and after it until the first read, `rd_data` is 0.
- R2: A read made while `busy` is high during an erase returns bit 7 equal to 0.
- R3: A read made while `busy` is high during a program returns bit 7 equal to the inverse of bit 7 of the `final_data` captured at the start of the operation.
- R4: The first status read of an operation returns bit 6 equal to 0. Each later status read within the same operation returns bit 6 inverted from the previous status read.
- R5: In every status read, all bits other than 7 and 6 are 0.
- R6: A read made while `busy` is low returns `array_data` as sampled in the read cycle. This applies from the first read after `busy` falls, so reads made after completion return identical values when the array word is unchanged. An erased word reads 0xFFFF.
- R7: Cycles without `rd_stb` leave `rd_data` unchanged and do not advance bit 6. Two status reads separated by idle cycles therefore differ in bit 6 exactly once.
- R8: A new operation restarts bit 6 at 0, whatever value it held when the previous operation ended.
- R9: Changes to `op_erase` and `final_data` while `busy` is high have no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | High while the external timer reports an operation in progress |
| op_erase | input | 1 | Operation type at start: 1 for erase, 0 for program |
| final_data | input | W | Word being programmed, captured at start |
| array_data | input | W | Array contents at the read address |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_data | output | W | Word returned to the host |

## Verification
The assertions assume that `busy` rises only from the array-read state. They also assume that `busy` stays low for at least one cycle between operations, so that every operation begins with a start transition. They treat `rd_stb` as a single-cycle pulse sampled at the clock edge.

The stimulus keeps to these assumptions. It drives all inputs at the falling edge. It always lowers `busy` and reads at least once before it starts the next operation. It issues every read as a one-cycle strobe. Idle gaps are inserted only between reads.

// File: rtl/poll_pkg.sv
package poll_pkg;
    typedef enum logic [1:0] {
        PS_ARRAY = 2'd0,
        PS_PROG  = 2'd1,
        PS_ERASE = 2'd2
    } poll_state_t;

    localparam int DQ7_POS = 7;
    localparam int DQ6_POS = 6;
endpackage

// File: rtl/poll_fsm.sv
module poll_fsm
    import poll_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         busy,
    input  logic         op_erase,
    input  logic [W-1:0] final_data,
    output poll_state_t  st,
    output logic         start,
    output logic         cur_erase,
    output logic [W-1:0] cur_data
);
    poll_state_t st_nx;
    logic [W-1:0] cap_data;

    // state register and capture at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= PS_ARRAY;
            cap_data <= '0;
        end else begin
            st <= st_nx;
            if (start) cap_data <= final_data;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            PS_ARRAY: if (busy) st_nx = op_erase ? PS_ERASE : PS_PROG;
            PS_PROG:  if (!busy) st_nx = PS_ARRAY;
            PS_ERASE: if (!busy) st_nx = PS_ARRAY;
            default:  st_nx = PS_ARRAY;
        endcase
    end

    // outputs: in the start cycle the live inputs stand in for the captured copy
    always_comb begin
        start     = (st == PS_ARRAY) && busy;
        cur_erase = (st == PS_ARRAY) ? op_erase : (st == PS_ERASE);
        cur_data  = (st == PS_ARRAY) ? final_data : cap_data;
    end
endmodule

// File: rtl/poll_toggle.sv
module poll_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stat_rd,
    output logic tog_cur
);
    logic tog_q;

    assign tog_cur = start ? 1'b0 : tog_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       tog_q <= 1'b0;
        else if (stat_rd) tog_q <= ~tog_cur;
        else if (start)   tog_q <= 1'b0;
    end
endmodule

// File: rtl/poll_outreg.sv
module poll_outreg
    import poll_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_stb,
    input  logic         busy,
    input  logic         cur_erase,
    input  logic [W-1:0] cur_data,
    input  logic         tog_cur,
    input  logic [W-1:0] array_data,
    output logic [W-1:0] rd_data
);
    localparam logic [W-1:0] DQ7_MASK = W'(1) << DQ7_POS;
    localparam logic [W-1:0] DQ6_MASK = W'(1) << DQ6_POS;

    logic [W-1:0] status;

    always_comb begin
        status = cur_erase ? '0 : (~cur_data & DQ7_MASK);
        if (tog_cur) status = status | DQ6_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= busy ? status : array_data;
    end
endmodule

// File: rtl/op_status_poller.sv
module op_status_poller
    import poll_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         busy,
    input  logic         op_erase,
    input  logic [W-1:0] final_data,
    input  logic [W-1:0] array_data,
    input  logic         rd_stb,
    output logic [W-1:0] rd_data
);
    poll_state_t  st;
    logic         start;
    logic         cur_erase;
    logic [W-1:0] cur_data;
    logic         tog_cur;
    logic         stat_rd;

    assign stat_rd = rd_stb && busy;

    poll_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
        .final_data(final_data), .st(st), .start(start),
        .cur_erase(cur_erase), .cur_data(cur_data)
    );

    poll_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .start(start), .stat_rd(stat_rd),
        .tog_cur(tog_cur)
    );

    poll_outreg #(.W(W)) u_out (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .busy(busy),
        .cur_erase(cur_erase), .cur_data(cur_data), .tog_cur(tog_cur),
        .array_data(array_data), .rd_data(rd_data)
    );
endmodule

// File: rtl/op_status_poller_chk.sv
module op_status_poller_chk
    import poll_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         rd_stb,
    input logic [W-1:0] array_data,
    input logic [W-1:0] rd_data,
    input poll_state_t  st,
    input logic         exp_d7
);
    logic seen;

    always_ff @(posedge clk) begin
        if (!rst_n)                 seen <= 1'b0;
        else if (busy && rd_stb)    seen <= 1'b1;
        else if (st == PS_ARRAY)    seen <= 1'b0;
    end

    a_r2_erase_dq7_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && st == PS_ERASE) |=> rd_data[DQ7_POS] == 1'b0);

    a_r3_prog_dq7_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && st == PS_PROG) |=> rd_data[DQ7_POS] == ~$past(exp_d7));

    a_r4_dq6_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && seen && st != PS_ARRAY) |=>
            rd_data[DQ6_POS] != $past(rd_data[DQ6_POS]));

    a_r5_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> (rd_data[5:0] == 6'd0));

    a_r6_array_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !busy) |=> rd_data == $past(array_data));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
endmodule

bind op_status_poller op_status_poller_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rd_stb(rd_stb),
    .array_data(array_data), .rd_data(rd_data), .st(st),
    .exp_d7(cur_data[poll_pkg::DQ7_POS])
);

// File: tb/sim_op_status_poller.sv
`timescale 1ns/1ps
module sim_op_status_poller;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         busy = 1'b0;
    logic         op_erase = 1'b0;
    logic [W-1:0] final_data = '0;
    logic [W-1:0] array_data = '0;
    logic         rd_stb = 1'b0;
    logic [W-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    op_status_poller #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
        .final_data(final_data), .array_data(array_data),
        .rd_stb(rd_stb), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(output logic [W-1:0] v);
        @(negedge clk) rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
        v = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic begin_op(input logic ers, input logic [W-1:0] d);
        @(negedge clk);
        op_erase = ers; final_data = d; busy = 1'b1;
    endtask

    task automatic end_op(input logic [W-1:0] arr);
        @(negedge clk);
        busy = 1'b0; array_data = arr;
    endtask

    task automatic t_reset;
        idle(3);
        check("R1 in reset", rd_data, 16'h0000);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        check("R1 after reset", rd_data, 16'h0000);
    endtask

    task automatic t_erase;
        logic [W-1:0] v;
        begin_op(1'b1, 16'h1234);
        rd(v); check("R2 R4 R5 first erase read", v, 16'h0000);
        rd(v); check("R4 second erase read", v, 16'h0040);
        op_erase = 1'b0; final_data = 16'h0000;
        rd(v); check("R9 op change ignored", v, 16'h0000);
        rd(v); check("R4 fourth erase read", v, 16'h0040);
        end_op(16'hFFFF);
        rd(v); check("R6 erased word", v, 16'hFFFF);
        rd(v); check("R6 repeat read", v, 16'hFFFF);
    endtask

    task automatic t_program_lowbit;
        logic [W-1:0] v;
        begin_op(1'b0, 16'h5555);
        rd(v); check("R3 R5 program dq7", v, 16'h0080);
        rd(v); check("R4 program toggle", v, 16'h00C0);
        rd(v); check("R4 program toggle back", v, 16'h0080);
        end_op(16'h5555);
        rd(v); check("R6 program done", v, 16'h5555);
    endtask

    task automatic t_program_highbit;
        logic [W-1:0] v;
        begin_op(1'b0, 16'hFF80);
        rd(v); check("R3 data bit7 set", v, 16'h0000);
        final_data = 16'h0000;
        rd(v); check("R9 data change ignored", v, 16'h0040);
        idle(5);
        check("R7 hold without read", rd_data, 16'h0040);
        rd(v); check("R7 single flip over gap", v, 16'h0000);
        rd(v); check("R4 odd end", v, 16'h0040);
        end_op(16'h0055);
        idle(2);
        check("R7 no read after done", rd_data, 16'h0040);
        rd(v); check("R6 first read after fall", v, 16'h0055);
    endtask

    task automatic t_restart;
        logic [W-1:0] v;
        begin_op(1'b1, 16'h0000);
        rd(v); check("R8 restart dq6 zero", v, 16'h0000);
        end_op(16'hA5A5);
        rd(v); check("R6 array value", v, 16'hA5A5);
        array_data = 16'h3C3C;
        rd(v); check("R6 array follows", v, 16'h3C3C);
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_erase;
                t_program_lowbit;
                t_program_highbit;
                t_restart;
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule